// File: doc/BRIEF.md
# Four-Source Interrupt Controller

This block keeps the flag and enable state for four interrupt sources of a small microcontroller core. The sources are an external pin with a selectable active edge, a one-cycle pulse marking the rollover of an 8-bit timer, a change on a 4-bit slice of an input port, and a completion pulse from the data EEPROM writer. Every flag latches its event whatever the enable bits say. Software clears a flag by writing a 0 to it. The block raises a request to the instruction sequencer and, while the core sleeps, a wake signal.

The port-change detector keeps a snapshot of the port slice. A port read by the core refreshes that snapshot. Any input-configured bit that differs from the snapshot sets the change flag again in every cycle, until a read removes the difference. A small sequencer-tracking state machine has three states. In `ST_RUN` the core runs normally. An acknowledge moves it to `ST_SVC`, which a return-from-interrupt leaves. A sleep request taken in `ST_RUN` moves it to `ST_DOZE`, which it leaves when the request drops. Acknowledge clears the global enable. Return-from-interrupt sets the global enable again.

Top module: `quad_intc`

## Requirements
- R1: After reset, `ctl_rd_data` reads 0x00. `eep_flag`, `irq`, `wake`, `asleep` and `in_svc` are all 0.
- R2: A cycle with `ctl_wr_en` high loads `ctl_wr_data` into the control register, which reads back on the next cycle. The bit layout is: [7] global enable, [6] EEPROM enable, [5] timer enable, [4] pin enable, [3] port-change enable, [2] timer flag, [1] pin flag, [0] port-change flag.
- R3: Each flag is set by its event whatever the enable bits and global enable hold. A flag stays set until software writes 0 to it. An event in the same cycle as such a write leaves the flag at 1.
- R4: The pin passes through a two-flop synchronizer and then an edge detector. With `edge_sel`=1 a rising edge sets flag [1]. With `edge_sel`=0 a falling edge sets it. The opposite edge has no effect. A pin change set up before clock edge N shows in the flag after edge N+2, and not after edge N+1.
- R5: A `tmr_wrap` pulse sets flag [2] on the next edge while `asleep` is 0. While `asleep` is 1 the pulse is ignored, because the timer is stopped.
- R6: `port_rd` captures `port_in` as the snapshot. Bits with `port_dir`=1 (input) are compared with the snapshot. Any difference sets flag [0] every cycle, so a software clear does not hold while the difference lasts. Bits with `port_dir`=0 are ignored.
- R7: In a cycle where `port_rd` is high, a difference from the old snapshot does not set flag [0].
- R8: `eep_done` sets `eep_flag` and `eep_clr` clears it. If both arrive in the same cycle, the flag ends up at 1.
- R9: `irq` is high exactly when the global enable is 1 and at least one of these pairs has both bits set: [5]/[2], [4]/[1], [3]/[0], or [6] with `eep_flag`.
- R10: `ack` clears the global enable on the next edge, and this takes priority over `reti` and over a write. `reti` sets it, and this takes priority over a write. `ack` taken in `ST_RUN` raises `in_svc` until a `reti` returns the machine to `ST_RUN`.
- R11: `sleep_en` taken in `ST_RUN` raises `asleep` on the next edge. `asleep` drops one edge after `sleep_en` falls. `wake` = `asleep` AND (([4] AND [1]) OR ([3] AND [0])), independent of the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous-release reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 8 | Control register write value |
| ctl_rd_data | output | 8 | Control register contents |
| edge_sel | input | 1 | 1 = rising, 0 = falling pin edge |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| tmr_wrap | input | 1 | Timer 0xFF to 0x00 rollover pulse |
| port_in | input | 4 | Live port slice |
| port_dir | input | 4 | Per-bit direction, 1 = input |
| port_rd | input | 1 | Core reads the port this cycle |
| eep_done | input | 1 | EEPROM write-complete pulse |
| eep_clr | input | 1 | Software clear of the EEPROM flag |
| eep_flag | output | 1 | EEPROM completion flag |
| ack | input | 1 | Sequencer takes the interrupt |
| reti | input | 1 | Return from interrupt |
| sleep_en | input | 1 | Core requests sleep |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake from sleep |
| asleep | output | 1 | Machine is in ST_DOZE |
| in_svc | output | 1 | Machine is in ST_SVC |

## Verification
The request logic is tried with a walked table of control values. The table sets flags without enables, enables without flags, matching pairs with and without the global enable, and the EEPROM flag alone. This separates a missing global gate from a wrong pairing of flag to enable. The pin path is probed for both polarities, with exact cycle counts that expose a missing or extra synchronizer stage. The port detector is driven with output-configured bits, a persisting mismatch against a clear, and a change during a read. The sleep cases show a timer pulse that is ignored and a port change that wakes with the global enable off.

// File: rtl/quad_intc_pkg.sv
package quad_intc_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_SVC  = 2'd1,
        ST_DOZE = 2'd2
    } intc_state_e;

    localparam int CTL_W = 8;
    localparam int B_GIE = 7;
    localparam int B_EEE = 6;
    localparam int B_TME = 5;
    localparam int B_PNE = 4;
    localparam int B_PCE = 3;
    localparam int B_TMF = 2;
    localparam int B_PNF = 1;
    localparam int B_PCF = 0;

endpackage

// File: rtl/intc_pin_edge.sv
module intc_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic rise_sel,
    output logic edge_hit
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   settled;
    logic                   last_q;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= pin_async;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    end

    assign settled = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= settled;
    end

    always_comb begin
        if (rise_sel) edge_hit = settled & ~last_q;
        else          edge_hit = ~settled & last_q;
    end
endmodule

// File: rtl/intc_port_change.sv
module intc_port_change #(
    parameter int PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_in,
    input  logic [PORT_W-1:0] port_dir,
    input  logic              port_rd,
    output logic              change
);
    logic [PORT_W-1:0] snap_q;
    logic [PORT_W-1:0] diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       snap_q <= '0;
        else if (port_rd) snap_q <= port_in;
    end

    always_comb begin
        diff   = (port_in ^ snap_q) & port_dir;
        change = (|diff) & ~port_rd;
    end
endmodule

// File: rtl/intc_seq_fsm.sv
module intc_seq_fsm
    import quad_intc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    input  logic reti,
    input  logic sleep_en,
    output logic asleep,
    output logic in_svc
);
    intc_state_e state_q;
    intc_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (ack)           state_d = ST_SVC;
                else if (sleep_en) state_d = ST_DOZE;
            end
            ST_SVC: begin
                if (reti) state_d = ST_RUN;
            end
            ST_DOZE: begin
                if (!sleep_en) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        asleep = 1'b0;
        in_svc = 1'b0;
        unique case (state_q)
            ST_RUN:  ;
            ST_SVC:  in_svc = 1'b1;
            ST_DOZE: asleep = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/quad_intc.sv
module quad_intc
    import quad_intc_pkg::*;
#(
    parameter int PORT_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_en,
    input  logic [7:0]        ctl_wr_data,
    output logic [7:0]        ctl_rd_data,
    input  logic              edge_sel,
    input  logic              ext_pin,
    input  logic              tmr_wrap,
    input  logic [PORT_W-1:0] port_in,
    input  logic [PORT_W-1:0] port_dir,
    input  logic              port_rd,
    input  logic              eep_done,
    input  logic              eep_clr,
    output logic              eep_flag,
    input  logic              ack,
    input  logic              reti,
    input  logic              sleep_en,
    output logic              irq,
    output logic              wake,
    output logic              asleep,
    output logic              in_svc
);
    logic [CTL_W-1:0] ctl_q;
    logic [CTL_W-1:0] ctl_d;
    logic             eep_q;
    logic             pin_hit;
    logic             port_chg;
    logic             pin_pair;
    logic             pc_pair;
    logic             tm_pair;
    logic             ee_pair;

    intc_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_async(ext_pin),
        .rise_sel (edge_sel),
        .edge_hit (pin_hit)
    );

    intc_port_change #(.PORT_W(PORT_W)) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .port_in (port_in),
        .port_dir(port_dir),
        .port_rd (port_rd),
        .change  (port_chg)
    );

    intc_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ack),
        .reti    (reti),
        .sleep_en(sleep_en),
        .asleep  (asleep),
        .in_svc  (in_svc)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_wr_en) ctl_d = ctl_wr_data;
        if (ack)       ctl_d[B_GIE] = 1'b0;
        else if (reti) ctl_d[B_GIE] = 1'b1;
        if (pin_hit)              ctl_d[B_PNF] = 1'b1;
        if (tmr_wrap && !asleep)  ctl_d[B_TMF] = 1'b1;
        if (port_chg)             ctl_d[B_PCF] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        eep_q <= 1'b0;
        else if (eep_done) eep_q <= 1'b1;
        else if (eep_clr)  eep_q <= 1'b0;
    end

    always_comb begin
        tm_pair  = ctl_q[B_TME] & ctl_q[B_TMF];
        pin_pair = ctl_q[B_PNE] & ctl_q[B_PNF];
        pc_pair  = ctl_q[B_PCE] & ctl_q[B_PCF];
        ee_pair  = ctl_q[B_EEE] & eep_q;
        irq      = ctl_q[B_GIE] & (tm_pair | pin_pair | pc_pair | ee_pair);
        wake     = asleep & (pin_pair | pc_pair);
    end

    assign ctl_rd_data = ctl_q;
    assign eep_flag    = eep_q;
endmodule

// File: rtl/quad_intc_chk.sv
module quad_intc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr_en,
    input logic       ack,
    input logic       reti,
    input logic       tmr_wrap,
    input logic       eep_done,
    input logic [7:0] ctl_rd_data,
    input logic       eep_flag,
    input logic       irq,
    input logic       wake,
    input logic       asleep,
    input logic       in_svc
);
    AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ctl_rd_data[7]); // R10
    AST_RETI_RAISES_GIE: assert property (@(posedge clk) disable iff (!rst_n) (reti && !ack) |=> ctl_rd_data[7]); // R10
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) irq |-> ctl_rd_data[7]); // R9
    AST_TMR_LATCH: assert property (@(posedge clk) disable iff (!rst_n) (tmr_wrap && !asleep) |=> ctl_rd_data[2]); // R5
    AST_EEP_LATCH: assert property (@(posedge clk) disable iff (!rst_n) eep_done |=> eep_flag); // R8
    AST_WAKE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n) wake |-> asleep); // R11
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ctl_rd_data[1] && !ctl_wr_en) |=> ctl_rd_data[1]); // R3
    AST_STATE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(asleep && in_svc)); // R10
endmodule

bind quad_intc quad_intc_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr_en  (ctl_wr_en),
    .ack        (ack),
    .reti       (reti),
    .tmr_wrap   (tmr_wrap),
    .eep_done   (eep_done),
    .ctl_rd_data(ctl_rd_data),
    .eep_flag   (eep_flag),
    .irq        (irq),
    .wake       (wake),
    .asleep     (asleep),
    .in_svc     (in_svc)
);

// File: tb/quad_intc_tb_top.sv
module quad_intc_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr_en = 1'b0;
    logic [7:0] ctl_wr_data = 8'h00;
    logic [7:0] ctl_rd_data;
    logic       edge_sel = 1'b1;
    logic       ext_pin = 1'b0;
    logic       tmr_wrap = 1'b0;
    logic [3:0] port_in = 4'h0;
    logic [3:0] port_dir = 4'h0;
    logic       port_rd = 1'b0;
    logic       eep_done = 1'b0;
    logic       eep_clr = 1'b0;
    logic       eep_flag;
    logic       ack = 1'b0;
    logic       reti = 1'b0;
    logic       sleep_en = 1'b0;
    logic       irq;
    logic       wake;
    logic       asleep;
    logic       in_svc;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    quad_intc dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .ctl_rd_data(ctl_rd_data), .edge_sel(edge_sel), .ext_pin(ext_pin),
        .tmr_wrap(tmr_wrap), .port_in(port_in), .port_dir(port_dir), .port_rd(port_rd),
        .eep_done(eep_done), .eep_clr(eep_clr), .eep_flag(eep_flag), .ack(ack),
        .reti(reti), .sleep_en(sleep_en), .irq(irq), .wake(wake), .asleep(asleep),
        .in_svc(in_svc)
    );

    // {control value, eep flag wanted, expected irq}
    localparam logic [9:0] VEC [0:9] = '{
        {8'h00, 1'b0, 1'b0},
        {8'hA4, 1'b0, 1'b1},
        {8'h24, 1'b0, 1'b0},
        {8'h92, 1'b0, 1'b1},
        {8'h8A, 1'b0, 1'b0},
        {8'h89, 1'b0, 1'b1},
        {8'hC0, 1'b1, 1'b1},
        {8'h40, 1'b1, 1'b0},
        {8'h87, 1'b1, 1'b0},
        {8'hB8, 1'b0, 1'b0}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_ctl(input logic [7:0] v);
        ctl_wr_en = 1'b1;
        ctl_wr_data = v;
        tick();
        ctl_wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1 reset state
        check("R1 ctl", ctl_rd_data, 8'h00);
        check("R1 irq", irq, 0);
        check("R1 wake", wake, 0);
        check("R1 asleep", asleep, 0);
        check("R1 in_svc", in_svc, 0);
        check("R1 eep", eep_flag, 0);
        rst_n = 1'b1;
        tick();
        check("R1 after release", ctl_rd_data, 8'h00);

        // R2 / R9 table walk
        for (int i = 0; i < 10; i++) begin
            if (VEC[i][1]) eep_done = 1'b1;
            else           eep_clr = 1'b1;
            tick();
            eep_done = 1'b0;
            eep_clr = 1'b0;
            write_ctl(VEC[i][9:2]);
            check("R2 readback", ctl_rd_data, VEC[i][9:2]);
            check("R9 irq", irq, VEC[i][0]);
        end
        eep_clr = 1'b1;
        write_ctl(8'h00);
        eep_clr = 1'b0;

        // R4 pin edges, rising
        edge_sel = 1'b1;
        ext_pin = 1'b1;
        tick(); tick();
        check("R4 rise not yet", ctl_rd_data[1], 0);
        tick();
        check("R4 rise latched R3", ctl_rd_data[1], 1);
        write_ctl(8'h00);
        ext_pin = 1'b0;
        repeat (4) tick();
        check("R4 falling ignored", ctl_rd_data[1], 0);
        edge_sel = 1'b0;
        ext_pin = 1'b1;
        repeat (4) tick();
        check("R4 rising ignored", ctl_rd_data[1], 0);
        ext_pin = 1'b0;
        repeat (4) tick();
        check("R4 fall latched", ctl_rd_data[1], 1);
        write_ctl(8'h00);

        // R5 timer, R3 event beats write
        tmr_wrap = 1'b1;
        tick();
        tmr_wrap = 1'b0;
        check("R5 timer flag", ctl_rd_data[2], 1);
        tmr_wrap = 1'b1;
        write_ctl(8'h00);
        tmr_wrap = 1'b0;
        check("R3 event wins write", ctl_rd_data[2], 1);
        write_ctl(8'h00);

        // R6 port change
        port_in = 4'b0100;
        port_dir = 4'b0000;
        tick(); tick();
        check("R6 output bit ignored", ctl_rd_data[0], 0);
        port_dir = 4'b0100;
        tick(); tick();
        check("R6 mismatch sets", ctl_rd_data[0], 1);
        write_ctl(8'h00);
        check("R6 reasserts", ctl_rd_data[0], 1);
        port_rd = 1'b1;
        tick();
        port_rd = 1'b0;
        write_ctl(8'h00);
        tick();
        check("R6 clear after read", ctl_rd_data[0], 0);

        // R7 change during read is missed
        port_in = 4'b0000;
        port_rd = 1'b1;
        tick();
        port_rd = 1'b0;
        tick();
        check("R7 read cycle miss", ctl_rd_data[0], 0);
        port_dir = 4'b0000;

        // R8 eeprom flag
        eep_done = 1'b1;
        tick();
        eep_done = 1'b0;
        check("R8 set", eep_flag, 1);
        eep_clr = 1'b1;
        tick();
        eep_clr = 1'b0;
        check("R8 clear", eep_flag, 0);
        eep_done = 1'b1; eep_clr = 1'b1;
        tick();
        eep_done = 1'b0; eep_clr = 1'b0;
        check("R8 set wins", eep_flag, 1);
        eep_clr = 1'b1;
        tick();
        eep_clr = 1'b0;

        // R10 ack / reti
        write_ctl(8'hA4);
        check("R10 irq before ack", irq, 1);
        ack = 1'b1;
        tick();
        ack = 1'b0;
        check("R10 ack clears gie", ctl_rd_data[7], 0);
        check("R10 irq dropped", irq, 0);
        check("R10 in service", in_svc, 1);
        reti = 1'b1;
        tick();
        reti = 1'b0;
        check("R10 reti sets gie", ctl_rd_data[7], 1);
        check("R10 left service", in_svc, 0);
        ack = 1'b1; reti = 1'b1;
        tick();
        ack = 1'b0; reti = 1'b0;
        check("R10 ack beats reti", ctl_rd_data[7], 0);
        reti = 1'b1;
        tick();
        reti = 1'b0;

        // R11 sleep and wake
        write_ctl(8'h08);
        sleep_en = 1'b1;
        tick();
        check("R11 asleep", asleep, 1);
        check("R11 no wake yet", wake, 0);
        tmr_wrap = 1'b1;
        tick();
        tmr_wrap = 1'b0;
        check("R5 timer stopped asleep", ctl_rd_data[2], 0);
        port_dir = 4'b0100;
        port_in = 4'b0100;
        tick();
        check("R11 wake on port change", wake, 1);
        check("R11 no irq without gie", irq, 0);
        sleep_en = 1'b0;
        tick();
        check("R11 left sleep", asleep, 0);
        check("R11 wake low awake", wake, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule